// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Front End

This block is the fetch half of a small microcontroller core whose program store sits on its own bus, separate from data. Each instruction cycle it presents a 13-bit program counter to the program store and captures the whole 14-bit word that comes back in the same cycle. That word is handed to the execute stage on the next cycle, together with a valid flag and the address it came from. Fetching instruction N+1 therefore overlaps executing instruction N, and a steady stream issues one instruction per cycle.

The execute stage steers the counter in two ways. It can write a full 13-bit address, or it can take a branch given as an 11-bit offset within a 2K-word page plus a 2-bit page number. Either redirect throws away the word already fetched and costs exactly one bubble before the target word reaches execute. A stall input freezes the counter and the instruction register so that no fetched word is lost.

Top module: `fetch_front`

## Requirements
- R1: While rst_ni is low, pmem_addr_o is 0x0000 and ir_valid_o is 0. Both take these values asynchronously as soon as reset asserts.
- R2: On a cycle with no stall, the full 14-bit pmem_data_i is captured into ir_o at the clock edge, and ir_pc_o takes the pmem_addr_o of that cycle.
- R3: With no stall and no redirect, ir_valid_o is 1 in every cycle after the first cycle following reset, so one instruction issues per cycle.
- R4: A sequential fetch advances pmem_addr_o by one. The increment wraps from 0x1FFF to 0x0000.
- R5: A taken branch (br_take_i=1) sets the next fetch address to {br_page_i, br_ofs_i}. The page number lands in address bits 12:11 and the offset in bits 10:0.
- R6: A PC write (pc_wr_i=1) sets the next fetch address to pc_wr_addr_i. When pc_wr_i and br_take_i are both 1, the PC write wins.
- R7: A redirect accepted on a cycle clears ir_valid_o for exactly the following cycle. On the cycle after that, ir_o holds the word at the target address with ir_valid_o=1.
- R8: While stall_i=1, pmem_addr_o, ir_o, ir_pc_o and ir_valid_o do not change. A branch or PC write presented during a stall is ignored.
- R9: When a stall ends, fetch resumes at the held address with no word skipped. A bubble that was held through the stall stays a single bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one instruction cycle per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze counter and instruction register |
| pc_wr_i | input | 1 | Execute stage writes the full program counter |
| pc_wr_addr_i | input | 13 | Full target address for a PC write |
| br_take_i | input | 1 | Execute stage takes a paged branch |
| br_page_i | input | 2 | Page number of the branch target |
| br_ofs_i | input | 11 | Offset of the branch target within its page |
| pmem_addr_o | output | 13 | Program store read address (current program counter) |
| pmem_data_i | input | 14 | Instruction word read from the program store, same cycle |
| ir_o | output | 14 | Instruction register presented to the execute stage |
| ir_pc_o | output | 13 | Address the instruction register was fetched from |
| ir_valid_o | output | 1 | Instruction register holds a word to execute |

## Verification
A wrong counter value is visible at pmem_addr_o at once. It reaches ir_pc_o and ir_o one edge later, so every step compares the address, the captured word and the source address of the word in the same cycle. A flush that is missing, or doubled, shows within one cycle of the redirect as a wrong ir_valid_o. A stall that leaks shows as a changed address or a lost word at the first edge of the stall. A wrong branch composition shows as a bad page or offset field in pmem_addr_o right after the branch, so targets are spread over all four pages and include the top address.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int ADDR_W = 13;
  localparam int INSN_W = 14;
  localparam int PAGE_W = 2;
  localparam int OFS_W  = ADDR_W - PAGE_W;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_WRITE  = 2'd2,
    SRC_HOLD   = 2'd3
  } pc_src_e;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    stall_i,
  input  logic    pc_wr_i,
  input  logic    br_take_i,
  output pc_src_e src_o,
  output logic    flush_o
);
  always_comb begin
    if (stall_i)        src_o = SRC_HOLD;
    else if (pc_wr_i)   src_o = SRC_WRITE;
    else if (br_take_i) src_o = SRC_BRANCH;
    else                src_o = SRC_SEQ;
  end

  assign flush_o = (src_o == SRC_WRITE) || (src_o == SRC_BRANCH);

  // redirect requests never reach the pipe during a stall
  p_stall_blocks_redirect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (src_o == SRC_HOLD) && !flush_o);

  // full write outranks paged branch
  p_write_priority_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && pc_wr_i && br_take_i) |-> (src_o == SRC_WRITE));
endmodule

// File: rtl/pc_gen.sv
module pc_gen
  import fetch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W,
  localparam int OW = AW - PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pc_src_e       src_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [PW-1:0] br_page_i,
  input  logic [OW-1:0] br_ofs_i,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_q, pc_d, br_tgt;

  generate
    if (PW > 0) begin : g_paged
      assign br_tgt = {br_page_i, br_ofs_i};
    end else begin : g_flat
      assign br_tgt = AW'(br_ofs_i);
    end
  endgenerate

  always_comb begin
    unique case (src_i)
      SRC_HOLD:   pc_d = pc_q;
      SRC_WRITE:  pc_d = wr_addr_i;
      SRC_BRANCH: pc_d = br_tgt;
      default:    pc_d = pc_q + AW'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  p_seq_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_SEQ) |=> pc_o == AW'($past(pc_o) + 1'b1));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_HOLD) |=> $stable(pc_o));

  p_branch_fields_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_BRANCH) |=> pc_o[OW-1:0] == $past(br_ofs_i));
endmodule

// File: rtl/ir_stage.sv
module ir_stage
  import fetch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = INSN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          flush_i,
  input  logic [IW-1:0] word_i,
  input  logic [AW-1:0] pc_i,
  output logic [IW-1:0] ir_o,
  output logic [AW-1:0] ir_pc_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_o    <= '0;
      ir_pc_o <= '0;
      valid_o <= 1'b0;
    end else if (!hold_i) begin
      ir_o    <= word_i;
      ir_pc_o <= pc_i;
      valid_o <= !flush_i;
    end
  end

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> (ir_o == $past(word_i)) && (ir_pc_o == $past(pc_i)));

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(ir_o) && $stable(ir_pc_o) && $stable(valid_o));
endmodule

// File: rtl/fetch_front.sv
module fetch_front
  import fetch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              pc_wr_i,
  input  logic [ADDR_W-1:0] pc_wr_addr_i,
  input  logic              br_take_i,
  input  logic [PAGE_W-1:0] br_page_i,
  input  logic [OFS_W-1:0]  br_ofs_i,
  output logic [ADDR_W-1:0] pmem_addr_o,
  input  logic [INSN_W-1:0] pmem_data_i,
  output logic [INSN_W-1:0] ir_o,
  output logic [ADDR_W-1:0] ir_pc_o,
  output logic              ir_valid_o
);
  pc_src_e src;
  logic    flush;
  logic    hold;

  fetch_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall_i),
    .pc_wr_i   (pc_wr_i),
    .br_take_i (br_take_i),
    .src_o     (src),
    .flush_o   (flush)
  );

  pc_gen #(.AW(ADDR_W), .PW(PAGE_W)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src),
    .wr_addr_i (pc_wr_addr_i),
    .br_page_i (br_page_i),
    .br_ofs_i  (br_ofs_i),
    .pc_o      (pmem_addr_o)
  );

  assign hold = (src == SRC_HOLD);

  ir_stage #(.AW(ADDR_W), .IW(INSN_W)) u_ir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (hold),
    .flush_i (flush),
    .word_i  (pmem_data_i),
    .pc_i    (pmem_addr_o),
    .ir_o    (ir_o),
    .ir_pc_o (ir_pc_o),
    .valid_o (ir_valid_o)
  );

  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (pmem_addr_o == '0) && !ir_valid_o);

  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && (pc_wr_i || br_take_i)) |=> !ir_valid_o);

  // a bubble never lasts past one unstalled cycle
  p_single_bubble_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ir_valid_o && !stall_i && !pc_wr_i && !br_take_i) |=> ir_valid_o);

  p_write_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && pc_wr_i) |=> pmem_addr_o == $past(pc_wr_addr_i));

  p_stream_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_valid_o && !stall_i && !pc_wr_i && !br_take_i) |=> ir_valid_o);
endmodule

// File: tb/fetch_front_test.sv
module fetch_front_test;
  import fetch_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              stall, wr, br;
  logic [ADDR_W-1:0] wr_addr;
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  logic [ADDR_W-1:0] addr;
  logic [INSN_W-1:0] data;
  logic [INSN_W-1:0] ir;
  logic [ADDR_W-1:0] ir_pc;
  logic              ir_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  function automatic logic [INSN_W-1:0] word_at(logic [ADDR_W-1:0] a);
    return {a[0], a} ^ 14'h1A5C;
  endfunction

  assign data = word_at(addr);

  fetch_front uut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
    .pc_wr_i(wr), .pc_wr_addr_i(wr_addr),
    .br_take_i(br), .br_page_i(page), .br_ofs_i(ofs),
    .pmem_addr_o(addr), .pmem_data_i(data),
    .ir_o(ir), .ir_pc_o(ir_pc), .ir_valid_o(ir_v)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        stall;
    logic        wr;
    logic [12:0] wr_addr;
    logic        br;
    logic [1:0]  page;
    logic [10:0] ofs;
    logic        exp_v;
    logic [12:0] exp_pc;
    logic [12:0] exp_addr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 13'h0000, 1'b0, 2'd0, 11'h000, 1'b1, 13'h0000, 13'h0001}, // R2 R3
    '{1'b0, 1'b0, 13'h0000, 1'b0, 2'd0, 11'h000, 1'b1, 13'h0001, 13'h0002}, // R3 R4
    '{1'b0, 1'b0, 13'h0000, 1'b1, 2'd1, 11'h123, 1'b0, 13'h0000, 13'h0923}, // R5 R7
    '{1'b0, 1'b0, 13'h0000, 1'b0, 2'd0, 11'h000, 1'b1, 13'h0923, 13'h0924}, // R7
    '{1'b0, 1'b1, 13'h1FFE, 1'b1, 2'd2, 11'h005, 1'b0, 13'h0000, 13'h1FFE}, // R6
    '{1'b0, 1'b0, 13'h0000, 1'b0, 2'd0, 11'h000, 1'b1, 13'h1FFE, 13'h1FFF}, // R7
    '{1'b0, 1'b0, 13'h0000, 1'b0, 2'd0, 11'h000, 1'b1, 13'h1FFF, 13'h0000}, // R4 wrap
    '{1'b0, 1'b0, 13'h0000, 1'b0, 2'd0, 11'h000, 1'b1, 13'h0000, 13'h0001}, // R4
    '{1'b1, 1'b0, 13'h0000, 1'b0, 2'd0, 11'h000, 1'b1, 13'h0000, 13'h0001}, // R8
    '{1'b1, 1'b0, 13'h0000, 1'b1, 2'd3, 11'h055, 1'b1, 13'h0000, 13'h0001}, // R8 ignore
    '{1'b0, 1'b0, 13'h0000, 1'b0, 2'd0, 11'h000, 1'b1, 13'h0001, 13'h0002}, // R9
    '{1'b0, 1'b0, 13'h0000, 1'b1, 2'd3, 11'h7FF, 1'b0, 13'h0000, 13'h1FFF}, // R5
    '{1'b0, 1'b0, 13'h0000, 1'b0, 2'd0, 11'h000, 1'b1, 13'h1FFF, 13'h0000}  // R7 R4
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    stall = 0; wr = 0; br = 0; wr_addr = '0; page = '0; ofs = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", 32'(addr), 32'h0);
    chk("R1 reset valid", 32'(ir_v), 32'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      stall = VEC[i].stall; wr = VEC[i].wr; wr_addr = VEC[i].wr_addr;
      br = VEC[i].br; page = VEC[i].page; ofs = VEC[i].ofs;
      @(posedge clk); #1;
      chk($sformatf("R7/R3 valid step %0d", i), 32'(ir_v), 32'(VEC[i].exp_v));
      chk($sformatf("R4/R5/R6 addr step %0d", i), 32'(addr), 32'(VEC[i].exp_addr));
      if (VEC[i].exp_v) begin
        chk($sformatf("R2 ir_pc step %0d", i), 32'(ir_pc), 32'(VEC[i].exp_pc));
        chk($sformatf("R2 word step %0d", i), 32'(ir), 32'(word_at(VEC[i].exp_pc)));
      end
      @(negedge clk);
    end

    // stall held over a bubble keeps a single bubble (R9)
    stall = 0; wr = 0; br = 1; page = 2'd0; ofs = 11'h040;
    @(posedge clk); #1;
    chk("R7 bubble valid", 32'(ir_v), 32'h0);
    chk("R5 page0 target", 32'(addr), 32'h0040);
    @(negedge clk);
    br = 0; stall = 1;
    @(posedge clk); #1;
    chk("R8 bubble held", 32'(ir_v), 32'h0);
    chk("R8 addr held", 32'(addr), 32'h0040);
    @(negedge clk);
    stall = 0;
    @(posedge clk); #1;
    chk("R9 resume valid", 32'(ir_v), 32'h1);
    chk("R9 resume pc", 32'(ir_pc), 32'h0040);
    chk("R9 resume word", 32'(ir), 32'(word_at(13'h0040)));
    chk("R9 next addr", 32'(addr), 32'h0041);

    // asynchronous reset mid-stream
    @(negedge clk);
    #1 rst_n = 0;
    #1;
    chk("R1 async addr", 32'(addr), 32'h0);
    chk("R1 async valid", 32'(ir_v), 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 first word pc", 32'(ir_pc), 32'h0);
    chk("R3 first word valid", 32'(ir_v), 32'h1);
    finish_run();
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end
endmodule